// File: doc/BRIEF.md
# Multi-Level GPU Page Table Walker

This block turns a GPU virtual address belonging to one VM context into a physical address. It takes the context settings as plain inputs: start address, table base, walk depth and table block size. It then reads 8-byte table entries over a simple request/response memory port. It follows zero or more directory levels and then reads one leaf entry. The result is a physical address, a flag that says whether that address lies in system memory or local memory, and a transfer length that never crosses a 4 KB page.

A caller places an address and a byte length on the request port. The caller then waits for the one-cycle `done` pulse and reads the result outputs. If any entry the walk needs has its valid bit clear, the walker stops at once and reports a fault. Only one walk is in progress at a time. Caching of entries and permission checks are handled elsewhere.

Top module: `gpu_pt_walker`

## Requirements
- R1: The walk uses an offset address, equal to the request address minus the context start. The context start is `{cfg_start_hi, cfg_start_lo, 12'h000}`, which is the low word shifted left by 12 plus the high word shifted left by 44.
- R2: The effective block size S equals `cfg_blk`, except that a value of 0 counts as 4. A walk with `cfg_blk` = 0 gives the same result as the same walk with `cfg_blk` = 4.
- R3: With depth D ≥ 1, the top table sits at `cfg_base << 12`. The top index is the offset shifted right by (D·9 + 8 + S), with no mask applied. Every entry address equals the table address plus index × 8, so it is 8-byte aligned.
- R4: Each lower directory level d (counting down toward 1) indexes with the offset shifted right by (d·9 + 8 + S), masked to 9 bits. A directory entry gives the next table address in bits 47:12, with the low 12 bits zero. Bit 0 of a directory entry is its valid bit.
- R5: The leaf index is the offset shifted right by (8 + S), masked to (9 + S) bits. The leaf is read from the table that the last directory entry named.
- R6: In a leaf entry, bits 47:12 hold the page base, bit 1 is the system-memory flag and bit 0 is the valid bit. The physical address equals the page base plus offset bits 11:0. The `sys_mem` output copies bit 1.
- R7: With depth 0, no directory is read. `cfg_base` itself is decoded as a directory entry: fragment size in bits 63:59, table in bits 47:12, valid in bit 0. The leaf index is the offset shifted right by (12 + fragment size), with no mask. The leaf read is issued in the cycle after the request is accepted.
- R8: The chunk length is 0x1000 minus offset bits 11:0 when those bits plus the requested length reach 0x1000 or more. Otherwise it is the requested length.
- R9: When an entry read returns valid = 0, or a depth-0 base has valid = 0, the walker pulses `done` with `fault` = 1 and issues no further reads for that request. For an invalid depth-0 base, this happens in the cycle after acceptance.
- R10: `req_ready` is low while a walk is running. A memory request holds its valid and address until it is accepted. `done` is high for exactly one cycle.
- R11: After reset, `req_ready` = 1 and `mem_req_valid`, `done` and `fault` are 0. The outputs `fault`, `phys_addr`, `sys_mem` and `chunk_len` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_lo | input | 32 | Context start, address bits 43:12 |
| cfg_start_hi | input | 20 | Context start, address bits 63:44 |
| cfg_base | input | 64 | Table base register |
| cfg_depth | input | DW | Number of directory levels |
| cfg_blk | input | BW | Block size field (0 means 4) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 64 | Virtual address to translate |
| req_len | input | LW | Requested byte length |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle result pulse |
| fault | output | 1 | Walk hit an invalid entry |
| phys_addr | output | 64 | Translated physical address |
| sys_mem | output | 1 | Result lies in system memory |
| chunk_len | output | LW | Length clipped at the 4 KB page |

## Verification
The assertions check on every cycle the properties that do not depend on table contents:
- the handshake rules of R10, including request stability and the single-cycle `done`;
- 8-byte alignment of entry addresses;
- the page-boundary bound on chunk length;
- the fact that outputs change only when `done` is high;
- the first-cycle behaviour of depth-0 walks.

The index arithmetic cannot be judged without a model of the tables, so only the bench scenarios can show it. This covers the shift and mask per level, the unmasked top index, the block-size remapping, the offset subtraction, and the choice of which table each level reads. The bench shows these by comparing the physical address, flag, chunk length and number of reads against its own walk over a randomly built memory.

// File: rtl/gpu_pt_walker.sv
module gpu_pt_walker #(
  parameter int LW = 32,
  parameter int DW = 3,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cfg_start_lo,
  input  logic [19:0]   cfg_start_hi,
  input  logic [63:0]   cfg_base,
  input  logic [DW-1:0] cfg_depth,
  input  logic [BW-1:0] cfg_blk,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [63:0]   req_vaddr,
  input  logic [LW-1:0] req_len,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [63:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data,
  output logic          done,
  output logic          fault,
  output logic [63:0]   phys_addr,
  output logic          sys_mem,
  output logic [LW-1:0] chunk_len
);
  localparam logic [63:0] TBL_MASK = 64'h0000_FFFF_FFFF_F000;
  localparam int SW = BW + 1;
  localparam logic [LW:0] PAGE = (LW+1)'(4096);

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT} st_t;
  st_t st;

  logic [63:0]   off, tbl;
  logic [SW-1:0] s_eff;
  logic [DW-1:0] lvl;
  logic [4:0]    frag;
  logic          first, leaf, flat;
  logic [LW-1:0] len;

  logic [7:0]  shamt;
  logic [63:0] raw, mask, idx;
  logic [LW:0] reach;
  logic [63:0] start_full;
  logic        unused_bits;

  assign start_full = {cfg_start_hi, cfg_start_lo, 12'h000};

  always_comb begin
    if (flat)
      shamt = 8'd12 + 8'(frag);
    else if (leaf)
      shamt = 8'd8 + 8'(s_eff);
    else
      shamt = 8'(lvl) * 8'd9 + 8'd8 + 8'(s_eff);
  end

  always_comb begin
    if (flat || (!leaf && first))
      mask = '1;
    else if (leaf)
      mask = (64'd1 << (8'd9 + 8'(s_eff))) - 64'd1;
    else
      mask = 64'h1FF;
  end

  assign raw          = off >> shamt;
  assign idx          = raw & mask;
  assign mem_req_addr = tbl + {idx[60:0], 3'b000};
  assign mem_req_valid = (st == ISSUE);
  assign req_ready    = (st == IDLE);
  assign reach        = (LW+1)'(off[11:0]) + {1'b0, len};

  assign unused_bits = ^{cfg_base[58:52], mem_rsp_data[63:48], mem_rsp_data[11:2], idx[63:61]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      off       <= '0;
      tbl       <= '0;
      s_eff     <= '0;
      lvl       <= '0;
      frag      <= '0;
      first     <= 1'b0;
      leaf      <= 1'b0;
      flat      <= 1'b0;
      len       <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      phys_addr <= '0;
      sys_mem   <= 1'b0;
      chunk_len <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          off   <= req_vaddr - start_full;
          s_eff <= (cfg_blk == '0) ? SW'(4) : SW'(cfg_blk);
          len   <= req_len;
          first <= 1'b1;
          if (cfg_depth == '0) begin
            if (!cfg_base[0]) begin
              done      <= 1'b1;
              fault     <= 1'b1;
              phys_addr <= '0;
              sys_mem   <= 1'b0;
              chunk_len <= '0;
            end else begin
              tbl  <= cfg_base & TBL_MASK;
              frag <= cfg_base[63:59];
              flat <= 1'b1;
              leaf <= 1'b1;
              st   <= ISSUE;
            end
          end else begin
            tbl  <= cfg_base << 12;
            lvl  <= cfg_depth;
            flat <= 1'b0;
            leaf <= 1'b0;
            st   <= ISSUE;
          end
        end
        ISSUE: if (mem_req_ready) st <= WAIT;
        WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            done      <= 1'b1;
            fault     <= 1'b1;
            phys_addr <= '0;
            sys_mem   <= 1'b0;
            chunk_len <= '0;
            st        <= IDLE;
          end else if (!leaf) begin
            tbl   <= mem_rsp_data & TBL_MASK;
            first <= 1'b0;
            if (lvl == DW'(1)) leaf <= 1'b1;
            else               lvl  <= lvl - DW'(1);
            st    <= ISSUE;
          end else begin
            done      <= 1'b1;
            fault     <= 1'b0;
            phys_addr <= (mem_rsp_data & TBL_MASK) + {52'd0, off[11:0]};
            sys_mem   <= mem_rsp_data[1];
            chunk_len <= (reach >= PAGE) ? LW'(PAGE - (LW+1)'(off[11:0])) : len;
            st        <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gpu_pt_walker_chk.sv
module gpu_pt_walker_chk #(
  parameter int LW = 32,
  parameter int DW = 3,
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [63:0]   cfg_base,
  input logic [DW-1:0] cfg_depth,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [63:0]   mem_req_addr,
  input logic          done,
  input logic          fault,
  input logic [63:0]   phys_addr,
  input logic          sys_mem,
  input logic [LW-1:0] chunk_len
);
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_entry_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  p_chunk_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (({1'b0, chunk_len} + (LW+1)'(phys_addr[11:0])) <= (LW+1)'(4096)));

  p_flat_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cfg_depth == '0 && !cfg_base[0]) |=> (done && fault && !mem_req_valid));

  p_flat_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cfg_depth == '0 && cfg_base[0]) |=> mem_req_valid);

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(phys_addr) && $stable(fault) && $stable(sys_mem) && $stable(chunk_len)));
endmodule

bind gpu_pt_walker gpu_pt_walker_chk #(.LW(LW), .DW(DW), .BW(BW)) u_chk (.*);

// File: tb/sim_gpu_pt_walker.sv
`timescale 1ns/1ps
module sim_gpu_pt_walker;
  localparam int LW = 32, DW = 3, BW = 4;
  localparam logic [63:0] M = 64'h0000_FFFF_FFFF_F000;

  logic clk = 0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [31:0]   cfg_start_lo;
  logic [19:0]   cfg_start_hi;
  logic [63:0]   cfg_base;
  logic [DW-1:0] cfg_depth;
  logic [BW-1:0] cfg_blk;
  logic          req_valid, req_ready;
  logic [63:0]   req_vaddr;
  logic [LW-1:0] req_len;
  logic          mem_req_valid, mem_req_ready;
  logic [63:0]   mem_req_addr;
  logic          mem_rsp_valid;
  logic [63:0]   mem_rsp_data;
  logic          done, fault, sys_mem;
  logic [63:0]   phys_addr;
  logic [LW-1:0] chunk_len;

  gpu_pt_walker #(.LW(LW), .DW(DW), .BW(BW)) u0 (.*);

  logic [63:0] mem [logic [63:0]];
  int nchk = 0, nfail = 0, nrd = 0, inv_pct = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(bit is_leaf);
    logic [63:0] e;
    e = {$urandom, $urandom} & M;
    if (is_leaf) e[6:1] = 6'($urandom);
    else e[63:59] = 5'($urandom);
    e[0] = (($urandom % 100) >= inv_pct);
    return e;
  endfunction

  function automatic logic [63:0] rd(logic [63:0] a, bit build, bit is_leaf);
    if (!mem.exists(a)) begin
      if (!build) return 64'd0;
      mem[a] = mk(is_leaf);
    end
    return mem[a];
  endfunction

  function automatic void ref_walk(input bit build, input logic [63:0] va, input logic [31:0] len,
                                   input logic [31:0] lo, input logic [19:0] hi, input logic [63:0] base,
                                   input int depth, input int blk,
                                   output bit f, output logic [63:0] pa, output bit sys,
                                   output logic [31:0] ch, output int nr);
    logic [63:0] off, tbl, idx, e;
    int s;
    off = va - {hi, lo, 12'h000};
    s = (blk == 0) ? 4 : blk;
    f = 0; pa = 0; sys = 0; ch = 0; nr = 0;
    if (depth == 0) begin
      if (!base[0]) begin f = 1; return; end
      tbl = base & M;
      idx = off >> (12 + int'(base[63:59]));
    end else begin
      tbl = base << 12;
      for (int d = depth; d >= 1; d--) begin
        idx = off >> (d * 9 + 8 + s);
        if (d != depth) idx = idx & 64'h1FF;
        e = rd(tbl + (idx << 3), build, 0);
        nr++;
        if (!e[0]) begin f = 1; return; end
        tbl = e & M;
      end
      idx = (off >> (8 + s)) & ((64'd1 << (9 + s)) - 64'd1);
    end
    e = rd(tbl + (idx << 3), build, 1);
    nr++;
    if (!e[0]) begin f = 1; return; end
    pa = (e & M) + {52'd0, off[11:0]};
    sys = e[1];
    ch = ((33'(off[11:0]) + 33'(len)) >= 33'd4096) ? 32'd4096 - 32'(off[11:0]) : len;
  endfunction

  // memory responder: random ready and latency
  initial begin
    bit busy = 0;
    int lat = 0;
    logic [63:0] ra = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(posedge clk);
      mem_rsp_valid <= 1'b0;
      if (!rst_n) begin
        busy = 0;
        mem_req_ready <= 1'b0;
      end else begin
        if (mem_req_valid && mem_req_ready) begin
          busy = 1; ra = mem_req_addr; lat = $urandom % 3; nrd++;
        end else if (busy) begin
          if (lat == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(ra) ? mem[ra] : 64'd0;
            busy = 0;
          end else lat--;
        end
        mem_req_ready <= !busy && ($urandom % 4 != 0);
      end
    end
  end

  bit r2_f; logic [63:0] r2_pa;

  task automatic run(string tag, bit build, logic [63:0] va, logic [31:0] len, logic [31:0] lo,
                     logic [19:0] hi, logic [63:0] base, int depth, int blk);
    bit ef, es; logic [63:0] epa; logic [31:0] ech; int enr;
    int wd = 0; bit ovl = 0;
    if (build) ref_walk(1, va, len, lo, hi, base, depth, blk, ef, epa, es, ech, enr);
    ref_walk(0, va, len, lo, hi, base, depth, blk, ef, epa, es, ech, enr);
    @(negedge clk);
    cfg_start_lo = lo; cfg_start_hi = hi; cfg_base = base;
    cfg_depth = DW'(depth); cfg_blk = BW'(blk);
    req_vaddr = va; req_len = len; req_valid = 1;
    while (!req_ready) @(negedge clk);
    nrd = 0;
    @(negedge clk);
    req_valid = 0;
    while (!done && wd < 2000) begin
      if (mem_req_valid && req_ready) ovl = 1;
      @(negedge clk);
      wd++;
    end
    chk({tag, " R10 walk completes"}, 64'(done), 64'd1);
    chk({tag, " R10 busy while walking"}, 64'(ovl), 64'd0);
    chk({tag, " R9 fault"}, 64'(fault), 64'(ef));
    chk({tag, " R9 read count"}, 64'(nrd), 64'(enr));
    if (!ef) begin
      chk({tag, " R6 phys_addr"}, phys_addr, epa);
      chk({tag, " R6 sys_mem"}, 64'(sys_mem), 64'(es));
      chk({tag, " R8 chunk_len"}, 64'(chunk_len), 64'(ech));
    end
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, 64'(done), 64'd0);
    r2_f = fault; r2_pa = phys_addr;
  endtask

  initial begin
    #(8 * 190000);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [63:0] a0, pa4;
    rst_n = 0; req_valid = 0; req_vaddr = 0; req_len = 0;
    cfg_start_lo = 0; cfg_start_hi = 0; cfg_base = 0; cfg_depth = 0; cfg_blk = 0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset req_ready", 64'(req_ready), 64'd1);
    chk("R11 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk("R11 reset done", 64'(done), 64'd0);
    chk("R11 reset fault", 64'(fault), 64'd0);

    inv_pct = 0;
    // R1 R3 R4 R5: two directory levels, nonzero context start
    run("R1/R3/R4/R5 depth2", 1, 64'h0000_1234_5678_9ABC, 32'd64, 32'h0000_0100, 20'h0, 64'h0_0000_4567, 2, 0);
    pa4 = r2_pa;
    // R2: block size 4 behaves like 0
    run("R2 blk4", 1, 64'h0000_1234_5678_9ABC, 32'd64, 32'h0000_0100, 20'h0, 64'h0_0000_4567, 2, 4);
    chk("R2 blk0 equals blk4", r2_pa, pa4);
    run("R3 depth3 blk7", 1, 64'h0000_7F00_1357_2468, 32'd16, 32'h0, 20'h0, 64'h0_0000_0ABC, 3, 7);
    // R8 chunk corners
    run("R8 end of page", 1, 64'h0000_0000_0040_1FF8, 32'd8, 32'h0, 20'h0, 64'h0_0000_0111, 1, 0);
    run("R8 cross by one", 1, 64'h0000_0000_0040_1FF8, 32'd9, 32'h0, 20'h0, 64'h0_0000_0111, 1, 0);
    run("R8 full page", 1, 64'h0000_0000_0040_3000, 32'h1000, 32'h0, 20'h0, 64'h0_0000_0111, 1, 0);
    run("R8 two pages", 1, 64'h0000_0000_0040_3000, 32'h2000, 32'h0, 20'h0, 64'h0_0000_0111, 1, 0);
    // R7 depth 0
    run("R7 depth0 frag0", 1, 64'h0000_0000_0123_4567, 32'd32, 32'h0, 20'h0, 64'h0000_0000_0800_0001, 0, 0);
    run("R7 depth0 frag5", 1, 64'h0000_0000_0123_4567, 32'd32, 32'h0, 20'h0, 64'h2800_0000_0900_0001, 0, 0);
    // R9 faults
    run("R9 depth0 invalid base", 0, 64'h0000_0000_0123_4567, 32'd32, 32'h0, 20'h0, 64'h0000_0000_0800_0000, 0, 0);
    a0 = (64'h0_0000_0999 << 12) + ((64'h0000_0000_0040_5000 >> 21) << 3);
    mem[a0] = 64'h0000_0000_0770_0001;
    run("R9 invalid leaf", 0, 64'h0000_0000_0040_5000, 32'd4, 32'h0, 20'h0, 64'h0_0000_0999, 1, 0);
    mem[a0] = 64'h0000_0000_0770_0000;
    run("R9 invalid directory", 0, 64'h0000_0000_0040_5000, 32'd4, 32'h0, 20'h0, 64'h0_0000_0999, 1, 0);

    // random walks
    inv_pct = 8;
    for (int i = 0; i < 300; i++) begin
      int dp, bk;
      logic [63:0] va, bs;
      logic [31:0] lo;
      dp = $urandom % 4;
      bk = $urandom % 16;
      lo = $urandom % 256;
      va = {16'h0, 16'($urandom), $urandom} + {20'h0, lo, 12'h0};
      bs = {$urandom, $urandom};
      if (dp == 0) begin
        bs = (bs & M) | 64'h1;
        bs[63:59] = 5'($urandom % 16);
        if ($urandom % 10 == 0) bs[0] = 0;
      end else bs = bs & 64'h0000_00FF_FFFF_FFFF;
      run("R1/R5/R6 random", 1, va, 32'($urandom % 9000), lo, 20'h0, bs, dp, bk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule